// File: doc/BRIEF.md
# TLB Maintenance Register Unit

This block holds the translation entries of a small, fully associative TLB. It also holds the four staging registers that software uses to maintain them: the high word (segment, virtual page and address-space tag), the low word (frame number and four flags), the index register with its probe-failure flag, and a free-running replacement pointer. Four single-cycle operations move data between the staging registers and the entry array: probe, read, indexed write and pointer-selected write. The whole array is driven out flat, so that the neighbouring address translator can compare against every entry.

The replacement pointer advances on every clock and never takes the value 0. A pointer-selected write therefore leaves entry 0 untouched. Entry 0 can be used as a pinned mapping that only an indexed write may change. At most one operation is strobed per cycle. An entry written at one clock edge shows on the table outputs, and takes part in a probe, from the next cycle onward.

Field layout at default widths: high word = {seg[25:24], vpn[23:6], asid[5:0]}; low word = {pfn[23:4], N[3], D[2], V[1], G[0]}.

Top module: `tlb_maint_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any write, the high word, low word, index and probe-failure flag read 0, every entry reads 0, and the replacement pointer reads TLB_SIZE-1.
- R2: The replacement pointer steps up by one on every clock edge, goes from TLB_SIZE-1 back to 1, and never reads 0.
- R3: A pointer-selected write stores the high and low words into the entry named by the pointer value seen at that edge; entry 0 is never changed by it.
- R4: An indexed write stores the high and low words into the entry named by the index register, entry 0 included.
- R5: A read loads the high and low words, at the next edge, from the entry named by the index register.
- R6: A probe hits an entry when its segment and page fields equal those of the high word and either its G flag (bit 0 of the low word) is 1 or its asid equals the high word's asid; on a hit the flag is cleared and the index takes the lowest hitting entry number.
- R7: A probe that hits nothing sets the probe-failure flag to 1 and leaves the index value unchanged.
- R8: Write enables for the high word, low word and index load the given data at the next edge; an index write does not alter the probe-failure flag.
- R9: An entry written at one edge is visible on the table outputs and to a probe from the following cycle.
- R10: When an operation updates a staging register in the same cycle as a software write of that register, the operation's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opProbe | input | 1 | Probe strobe |
| opRead | input | 1 | Read-entry strobe |
| opWriteIdx | input | 1 | Indexed-write strobe |
| opWriteRnd | input | 1 | Pointer-selected write strobe |
| hiWrEn | input | 1 | Load enable for the high word |
| hiWrData | input | HI_W (26) | High word data |
| loWrEn | input | 1 | Load enable for the low word |
| loWrData | input | LO_W (24) | Low word data |
| idxWrEn | input | 1 | Load enable for the index value |
| idxWrData | input | IDX_W (3) | Index value data |
| entryHi | output | HI_W (26) | High word register |
| entryLo | output | LO_W (24) | Low word register |
| indexVal | output | IDX_W (3) | Index value |
| probeFail | output | 1 | Probe-failure flag |
| randomVal | output | IDX_W (3) | Replacement pointer |
| tableHi | output | TLB_SIZE*HI_W (208) | All entry high words, entry k at bits k*HI_W upward |
| tableLo | output | TLB_SIZE*LO_W (192) | All entry low words, entry k at bits k*LO_W upward |

## Verification
A pointer that slips by one step shows at once on randomVal. A pointer-selected write then lands in a neighbouring slot, which shows on the table outputs one cycle later. A wrong probe priority or a wrong global-flag rule shows in indexVal and probeFail in the cycle after the probe. A stale or mis-addressed entry shows in the high and low words one cycle after a read. Entry 0 is compared before and after a full sweep of pointer-selected writes, so a pointer that reaches 0 is caught within TLB_SIZE cycles.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic writeEntry;
    logic readEntry;
    logic probe;
  } tlbm_ctl_t;
endpackage

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int TLB_SIZE = 8,
  parameter int IDX_W    = $clog2(TLB_SIZE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opProbe,
  input  logic             opRead,
  input  logic             opWriteIdx,
  input  logic             opWriteRnd,
  input  logic [IDX_W-1:0] indexVal,
  output tlbm_ctl_t        ctl,
  output logic [IDX_W-1:0] wrAddr,
  output logic [IDX_W-1:0] randomVal
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(TLB_SIZE - 1);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);

  logic [IDX_W-1:0] rndQ;

  // free-running replacement pointer over 1..TLB_SIZE-1
  always_ff @(posedge clk) begin
    if (!rstN)             rndQ <= LAST;
    else if (rndQ == LAST) rndQ <= FIRST;
    else                   rndQ <= rndQ + FIRST;
  end

  always_comb begin
    ctl.writeEntry = opWriteIdx | opWriteRnd;
    ctl.readEntry  = opRead;
    ctl.probe      = opProbe;
    wrAddr         = opWriteRnd ? rndQ : indexVal;
  end

  assign randomVal = rndQ;
endmodule

// File: rtl/tlbm_datapath.sv
module tlbm_datapath
  import tlbm_pkg::*;
#(
  parameter int TLB_SIZE = 8,
  parameter int HI_W     = 26,
  parameter int LO_W     = 24,
  parameter int ASID_W   = 6,
  parameter int IDX_W    = $clog2(TLB_SIZE)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tlbm_ctl_t                ctl,
  input  logic [IDX_W-1:0]         wrAddr,
  input  logic                     hiWrEn,
  input  logic [HI_W-1:0]          hiWrData,
  input  logic                     loWrEn,
  input  logic [LO_W-1:0]          loWrData,
  input  logic                     idxWrEn,
  input  logic [IDX_W-1:0]         idxWrData,
  output logic [HI_W-1:0]          entryHi,
  output logic [LO_W-1:0]          entryLo,
  output logic [IDX_W-1:0]         indexVal,
  output logic                     probeFail,
  output logic [TLB_SIZE*HI_W-1:0] tableHi,
  output logic [TLB_SIZE*LO_W-1:0] tableLo
);
  localparam int GLOBAL_BIT = 0;

  logic [HI_W-1:0]     hiMem [TLB_SIZE];
  logic [LO_W-1:0]     loMem [TLB_SIZE];
  logic [TLB_SIZE-1:0] hitVec;
  logic                anyHit;
  logic [IDX_W-1:0]    hitIdx;

  for (genvar e = 0; e < TLB_SIZE; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiMem[e] <= '0;
        loMem[e] <= '0;
      end else if (ctl.writeEntry && wrAddr == IDX_W'(e)) begin
        hiMem[e] <= entryHi;
        loMem[e] <= entryLo;
      end
    end

    // tag match: segment+page always, asid unless entry is global
    assign hitVec[e] = (hiMem[e][HI_W-1:ASID_W] == entryHi[HI_W-1:ASID_W]) &&
                       (loMem[e][GLOBAL_BIT] ||
                        hiMem[e][ASID_W-1:0] == entryHi[ASID_W-1:0]);

    assign tableHi[e*HI_W +: HI_W] = hiMem[e];
    assign tableLo[e*LO_W +: LO_W] = loMem[e];
  end

  // lowest-numbered hit wins
  always_comb begin
    hitIdx = '0;
    for (int i = TLB_SIZE - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end
  assign anyHit = |hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryHi   <= '0;
      entryLo   <= '0;
      indexVal  <= '0;
      probeFail <= 1'b0;
    end else begin
      if (ctl.readEntry)   entryHi <= hiMem[indexVal];
      else if (hiWrEn)     entryHi <= hiWrData;

      if (ctl.readEntry)   entryLo <= loMem[indexVal];
      else if (loWrEn)     entryLo <= loWrData;

      if (ctl.probe && anyHit) indexVal <= hitIdx;
      else if (idxWrEn)        indexVal <= idxWrData;

      if (ctl.probe) probeFail <= !anyHit;
    end
  end
endmodule

// File: rtl/tlb_maint_unit.sv
module tlb_maint_unit
  import tlbm_pkg::*;
#(
  parameter int TLB_SIZE = 8,
  parameter int SEG_W    = 2,
  parameter int VPN_W    = 18,
  parameter int ASID_W   = 6,
  parameter int PFN_W    = 20,
  localparam int HI_W    = SEG_W + VPN_W + ASID_W,
  localparam int LO_W    = PFN_W + 4,
  localparam int IDX_W   = $clog2(TLB_SIZE)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opProbe,
  input  logic                     opRead,
  input  logic                     opWriteIdx,
  input  logic                     opWriteRnd,
  input  logic                     hiWrEn,
  input  logic [HI_W-1:0]          hiWrData,
  input  logic                     loWrEn,
  input  logic [LO_W-1:0]          loWrData,
  input  logic                     idxWrEn,
  input  logic [IDX_W-1:0]         idxWrData,
  output logic [HI_W-1:0]          entryHi,
  output logic [LO_W-1:0]          entryLo,
  output logic [IDX_W-1:0]         indexVal,
  output logic                     probeFail,
  output logic [IDX_W-1:0]         randomVal,
  output logic [TLB_SIZE*HI_W-1:0] tableHi,
  output logic [TLB_SIZE*LO_W-1:0] tableLo
);
  tlbm_ctl_t        ctl;
  logic [IDX_W-1:0] wrAddr;

  tlbm_ctrl #(.TLB_SIZE(TLB_SIZE), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .opProbe(opProbe), .opRead(opRead),
    .opWriteIdx(opWriteIdx), .opWriteRnd(opWriteRnd),
    .indexVal(indexVal), .ctl(ctl), .wrAddr(wrAddr), .randomVal(randomVal)
  );

  tlbm_datapath #(.TLB_SIZE(TLB_SIZE), .HI_W(HI_W), .LO_W(LO_W),
                  .ASID_W(ASID_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr),
    .hiWrEn(hiWrEn), .hiWrData(hiWrData),
    .loWrEn(loWrEn), .loWrData(loWrData),
    .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .entryHi(entryHi), .entryLo(entryLo),
    .indexVal(indexVal), .probeFail(probeFail),
    .tableHi(tableHi), .tableLo(tableLo)
  );
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
  parameter int TLB_SIZE = 8,
  parameter int HI_W     = 26,
  parameter int LO_W     = 24,
  parameter int ASID_W   = 6,
  parameter int IDX_W    = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     opProbe,
  input logic                     opRead,
  input logic                     opWriteRnd,
  input logic                     idxWrEn,
  input logic [HI_W-1:0]          entryHi,
  input logic [LO_W-1:0]          entryLo,
  input logic [IDX_W-1:0]         indexVal,
  input logic                     probeFail,
  input logic [IDX_W-1:0]         randomVal,
  input logic [TLB_SIZE*HI_W-1:0] tableHi,
  input logic [TLB_SIZE*LO_W-1:0] tableLo
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TLB_SIZE - 1);

  logic [HI_W-1:0] selHi;
  logic [LO_W-1:0] selLo;
  assign selHi = tableHi[indexVal*HI_W +: HI_W];
  assign selLo = tableLo[indexVal*LO_W +: LO_W];

  AST_RANDOM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (randomVal != '0) && (randomVal <= LAST)); // R2
  AST_RANDOM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (randomVal == LAST) |=> (randomVal == IDX_W'(1))); // R2
  AST_RANDOM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (randomVal != LAST) |=> (randomVal == $past(randomVal) + IDX_W'(1))); // R2
  AST_ENTRY0_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    opWriteRnd |=> (tableHi[HI_W-1:0] == $past(tableHi[HI_W-1:0]) &&
                    tableLo[LO_W-1:0] == $past(tableLo[LO_W-1:0]))); // R3
  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    opRead |=> (entryHi == $past(selHi) && entryLo == $past(selLo))); // R5
  AST_HIT_TAG: assert property (@(posedge clk) disable iff (!rstN)
    opProbe |=> (probeFail ||
                 selHi[HI_W-1:ASID_W] == $past(entryHi[HI_W-1:ASID_W]))); // R6
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (opProbe && !idxWrEn) |=> (!probeFail || indexVal == $past(indexVal))); // R7
endmodule

bind tlb_maint_unit tlbm_checker #(
  .TLB_SIZE(TLB_SIZE), .HI_W(HI_W), .LO_W(LO_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .opProbe(opProbe), .opRead(opRead),
  .opWriteRnd(opWriteRnd), .idxWrEn(idxWrEn),
  .entryHi(entryHi), .entryLo(entryLo), .indexVal(indexVal),
  .probeFail(probeFail), .randomVal(randomVal),
  .tableHi(tableHi), .tableLo(tableLo)
);

// File: tb/tlb_maint_unit_test.sv
`timescale 1ns/1ps
module tlb_maint_unit_test;
  localparam int N = 8;
  localparam int HW = 26;
  localparam int LW = 24;
  localparam int IW = 3;

  typedef struct packed {
    logic [IW-1:0] idx;
    logic [HW-1:0] hi;
    logic [LW-1:0] lo;
  } vec_t;

  // {idx, hi={seg,vpn,asid}, lo={pfn,N,D,V,G}}
  localparam vec_t VECS [4] = '{
    '{idx: 3'd0, hi: {2'b10, 18'h00011, 6'd1}, lo: {20'h00AAA, 4'b0110}},
    '{idx: 3'd2, hi: {2'b10, 18'h00022, 6'd1}, lo: {20'h00BBB, 4'b0111}},
    '{idx: 3'd5, hi: {2'b11, 18'h00033, 6'd4}, lo: {20'h00CCC, 4'b0010}},
    '{idx: 3'd7, hi: {2'b10, 18'h00044, 6'd9}, lo: {20'h00DDD, 4'b1110}}
  };

  logic clk = 0, rstN = 0;
  logic opProbe = 0, opRead = 0, opWriteIdx = 0, opWriteRnd = 0;
  logic hiWrEn = 0, loWrEn = 0, idxWrEn = 0;
  logic [HW-1:0] hiWrData = '0;
  logic [LW-1:0] loWrData = '0;
  logic [IW-1:0] idxWrData = '0;
  logic [HW-1:0] entryHi;
  logic [LW-1:0] entryLo;
  logic [IW-1:0] indexVal, randomVal;
  logic probeFail;
  logic [N*HW-1:0] tableHi;
  logic [N*LW-1:0] tableLo;

  int checks = 0, fails = 0;
  logic [IW-1:0] expRnd;
  logic [HW-1:0] keepHi0;
  logic [LW-1:0] keepLo0;

  always #2.5 clk = ~clk;

  tlb_maint_unit uut (.*);

  // bench model of the replacement pointer
  always @(posedge clk) begin
    if (!rstN) expRnd <= 3'd7;
    else       expRnd <= (expRnd == 3'd7) ? 3'd1 : expRnd + 3'd1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs were set after a negedge; returns at next negedge
  task automatic step();
    @(negedge clk);
    opProbe = 0; opRead = 0; opWriteIdx = 0; opWriteRnd = 0;
    hiWrEn = 0; loWrEn = 0; idxWrEn = 0;
  endtask

  task automatic setRegs(input logic [IW-1:0] i, input logic [HW-1:0] h, input logic [LW-1:0] l);
    idxWrEn = 1; idxWrData = i; hiWrEn = 1; hiWrData = h; loWrEn = 1; loWrData = l;
    step();
  endtask

  function automatic logic [HW-1:0] tHi(input int k); return tableHi[k*HW +: HW]; endfunction
  function automatic logic [LW-1:0] tLo(input int k); return tableLo[k*LW +: LW]; endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 hi", entryHi, 0); chk("R1 lo", entryLo, 0);
    chk("R1 idx", indexVal, 0); chk("R1 pfail", probeFail, 0);
    chk("R1 rnd", randomVal, 7);
    rstN = 1;
    @(negedge clk);
    // R1: after release, before any write (pointer has already stepped once)
    chk("R1 table hi", tableHi, 0); chk("R1 table lo", tableLo, 0);
    chk("R1 idx after release", indexVal, 0);

    // R2: pointer sweep across two wraps
    for (int c = 0; c < 16; c++) begin
      chk("R2 pointer", randomVal, expRnd);
      @(negedge clk);
    end

    // R4/R9: indexed writes from the vector table
    foreach (VECS[v]) begin
      setRegs(VECS[v].idx, VECS[v].hi, VECS[v].lo);
      opWriteIdx = 1; step();
      chk("R4 R9 entry hi", tHi(VECS[v].idx), VECS[v].hi);
      chk("R4 R9 entry lo", tLo(VECS[v].idx), VECS[v].lo);
    end

    // R5: read back after scribbling the staging registers
    foreach (VECS[v]) begin
      setRegs(VECS[v].idx, 26'h3FFFFFF, 24'hFFFFFF);
      opRead = 1; step();
      chk("R5 read hi", entryHi, VECS[v].hi);
      chk("R5 read lo", entryLo, VECS[v].lo);
    end

    // R6: exact hit
    setRegs(3'd4, VECS[2].hi, '0);
    opProbe = 1; step();
    chk("R6 hit pfail", probeFail, 0); chk("R6 hit idx", indexVal, 5);
    // R6: global entry hits with another asid
    setRegs(3'd4, {2'b10, 18'h00022, 6'd30}, '0);
    opProbe = 1; step();
    chk("R6 global pfail", probeFail, 0); chk("R6 global idx", indexVal, 2);

    // R7: non-global entry with wrong asid misses, index kept
    setRegs(3'd6, {2'b11, 18'h00033, 6'd5}, '0);
    opProbe = 1; step();
    chk("R7 miss pfail", probeFail, 1); chk("R7 miss idx", indexVal, 6);
    // R8: index write leaves the flag alone
    idxWrEn = 1; idxWrData = 3'd3; step();
    chk("R8 idx write", indexVal, 3); chk("R8 pfail kept", probeFail, 1);

    // R6/R9: duplicate tag in entry 3, probe on next cycle picks lowest
    setRegs(3'd3, VECS[3].hi, VECS[3].lo);
    opWriteIdx = 1; step();
    opProbe = 1; step();
    chk("R6 R9 lowest idx", indexVal, 3); chk("R6 lowest pfail", probeFail, 0);

    // R10: read wins over same-cycle high-word write
    setRegs(3'd0, 26'h1234567, 24'h00F00F);
    opRead = 1; hiWrEn = 1; hiWrData = 26'h2AAAAAA; step();
    chk("R10 hi precedence", entryHi, VECS[0].hi);

    // R3: pointer-selected writes over a full sweep
    keepHi0 = tHi(0); keepLo0 = tLo(0);
    for (int k = 0; k < 9; k++) begin
      logic [IW-1:0] slot;
      logic [HW-1:0] h;
      h = {2'b01, 18'(k + 16'h0100), 6'(k)};
      hiWrEn = 1; hiWrData = h; loWrEn = 1; loWrData = 24'(k * 3 + 1); step();
      slot = randomVal;
      opWriteRnd = 1; step();
      chk("R3 rnd write hi", tHi(slot), h);
      chk("R3 rnd write lo", tLo(slot), 24'(k * 3 + 1));
    end
    chk("R3 entry0 hi kept", tHi(0), keepHi0);
    chk("R3 entry0 lo kept", tLo(0), keepLo0);

    finishRun();
  end
endmodule